// File: doc/BRIEF.md
# Hashed Requester-ID to Stream-ID Translator

This block turns a 16-bit PCIe requester ID (bus, device, function) into the stream ID that an IOMMU uses to pick a translation context. The mapping is held in a 256-word table of 32-bit entries that software loads through a plain write/read port. Each entry names the requester ID it serves, a stream ID relative to the controller's base, and a link to another slot. The links let several requester IDs whose hashes land in the same slot share one chain.

A lookup is presented with a valid/ready handshake. The block computes a CRC-8 of the requester ID to choose the first slot. It then reads one entry per clock and follows the links until the stored requester ID matches or the chain ends. When the walk finishes, the block pulses a done flag for one cycle. With it come a hit flag and the absolute stream ID, which is the programmable 8-bit base plus the stored relative value. Only one lookup runs at a time. While a walk is in flight, writes from software are stalled so that the chain cannot change under it.

Top module: `sid_hash_lookup`

## Requirements
- R1: After reset every table word reads as zero, the base reads as zero, `req_ready` and `cfg_ready` are 1, and `rsp_done` is 0.
- R2: A table write with `cfg_wr` high and `cfg_ready` high stores `cfg_wdata` at slot `cfg_addr` on that clock edge. `cfg_rdata` always shows the word at `cfg_addr` without a clock.
- R3: The first slot visited is the CRC-8 of the requester ID. The CRC uses polynomial 0x07 and initial value 0, and takes bits from bit 15 down to bit 0, so the bus byte goes first. It has no reflection and no final inversion. For example, ID 0x0100 starts at slot 21.
- R4: An entry is laid out as bits [31:16] stored requester ID, bits [15:8] relative stream ID, and bits [7:0] link to the next slot.
- R5: On a hit, `rsp_hit` is 1 and `rsp_sid` equals base plus relative ID, modulo 256.
- R6: When the stored ID differs and the link is non-zero, the walk moves to the linked slot. If a lookup ends at the n-th visited entry, `rsp_done` is high during the n-th cycle after the accepting clock edge.
- R7: The walk ends in a miss (`rsp_hit` 0, `rsp_sid` 0) when the visited entry does not match and either its link is 0 or the whole word is 0.
- R8: The match test is applied before the empty test, so requester ID 0x0000 hits on an all-zero word and returns base plus 0.
- R9: A lookup visits at most 256 entries. A chain that loops without a match ends in a miss after exactly 256 visits.
- R10: `req_ready` drops on the clock edge that accepts a request and rises again in the cycle where `rsp_done` is high. `rsp_done` is never high in two consecutive cycles.
- R11: While a lookup is in flight, `cfg_ready` is 0. Table and base writes offered in that time are discarded and change no stored state.
- R12: A base write with `cfg_base_wr` high and `cfg_ready` high loads `cfg_base_wdata`, which `cfg_base_rdata` then shows. Later lookups use the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| cfg_wr | input | 1 | Table write strobe |
| cfg_addr | input | 8 | Table slot for write and read |
| cfg_wdata | input | 32 | Table write data |
| cfg_base_wr | input | 1 | Base stream ID write strobe |
| cfg_base_wdata | input | 8 | New base stream ID |
| cfg_ready | output | 1 | Configuration writes are accepted |
| cfg_rdata | output | 32 | Table word at `cfg_addr` |
| cfg_base_rdata | output | 8 | Current base stream ID |
| req_valid | input | 1 | Lookup request valid |
| req_bdf | input | 16 | Requester ID to translate |
| req_ready | output | 1 | Block can accept a lookup |
| rsp_done | output | 1 | One-cycle pulse: lookup finished |
| rsp_hit | output | 1 | Lookup found a matching entry |
| rsp_sid | output | 8 | Absolute stream ID (0 on miss) |

## Verification
A wrong hash or wrong field slicing appears at the very first lookup as a miss, or as a hit with the wrong stream ID. The sweep over 256 requester IDs, each placed in its own computed slot, exposes this within a few cycles. A broken link-follow or a broken end-of-chain test shows up as a done pulse in the wrong cycle, because the bench counts the cycles of every walk. A broken visit limit shows up as either a hang or an early finish on a self-looping chain, and that is seen within 256 cycles. A lost hold-off shows up as a changed word or base when it is read back right after the walk.

// File: rtl/sid_lut_pkg.sv
package sid_lut_pkg;

  // Default geometry shared by the block and its checker.
  localparam int unsigned DEF_BDF_W = 16;
  localparam int unsigned DEF_SID_W = 8;
  localparam int unsigned DEF_IDX_W = 8;

  typedef enum logic {
    WK_IDLE = 1'b0,
    WK_RUN  = 1'b1
  } walk_state_e;

endpackage

// File: rtl/sid_slot_hash.sv
// Combinational CRC over the requester ID, MSB first, zero seed.
module sid_slot_hash #(
  parameter int unsigned          KEY_W = 16,
  parameter int unsigned          IDX_W = 8,
  parameter logic [IDX_W-1:0]     POLY  = 8'h07
) (
  input  logic [KEY_W-1:0] key,
  output logic [IDX_W-1:0] slot
);

  logic [IDX_W-1:0] acc;
  logic             fb;

  always_comb begin
    acc = '0;
    fb  = 1'b0;
    for (int b = KEY_W - 1; b >= 0; b--) begin
      fb  = acc[IDX_W-1] ^ key[b];
      acc = {acc[IDX_W-2:0], 1'b0};
      if (fb) begin
        acc = acc ^ POLY;
      end
    end
  end

  assign slot = acc;

endmodule

// File: rtl/sid_table_store.sv
// Register-file table: one write port, two combinational read ports.
module sid_table_store #(
  parameter int unsigned ENTRY_W = 32,
  parameter int unsigned IDX_W   = 8,
  localparam int unsigned DEPTH  = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic [IDX_W-1:0]   rd_a_idx,
  output logic [ENTRY_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]   rd_b_idx,
  output logic [ENTRY_W-1:0] rd_b_data
);

  logic [ENTRY_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g] <= '0;
      end else if (slot_en) begin
        mem[g] <= wr_data;
      end
    end
  end

  assign rd_a_data = mem[rd_a_idx];
  assign rd_b_data = mem[rd_b_idx];

endmodule

// File: rtl/sid_chain_walker.sv
// Walks one chain entry per cycle and registers the result.
module sid_chain_walker
  import sid_lut_pkg::*;
#(
  parameter int unsigned BDF_W = 16,
  parameter int unsigned SID_W = 8,
  parameter int unsigned IDX_W = 8,
  localparam int unsigned DEPTH   = 1 << IDX_W,
  localparam int unsigned ENTRY_W = BDF_W + SID_W + IDX_W,
  localparam int unsigned CNT_W   = IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [BDF_W-1:0]   start_bdf,
  input  logic [IDX_W-1:0]   start_slot,
  input  logic [ENTRY_W-1:0] ent,
  input  logic [SID_W-1:0]   base_sid,
  output logic               busy,
  output logic [IDX_W-1:0]   rd_idx,
  output logic               done,
  output logic               hit,
  output logic [SID_W-1:0]   sid
);

  walk_state_e      st_q, st_n;
  logic [BDF_W-1:0] key_q, key_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [CNT_W-1:0] vis_q, vis_n;
  logic             done_q, done_n;
  logic             hit_q, hit_n;
  logic [SID_W-1:0] sid_q, sid_n;

  logic [BDF_W-1:0] ent_bdf;
  logic [SID_W-1:0] ent_rel;
  logic [IDX_W-1:0] ent_nxt;
  logic             is_match, is_empty, is_tail, is_spent;

  assign ent_bdf  = ent[ENTRY_W-1 -: BDF_W];
  assign ent_rel  = ent[IDX_W +: SID_W];
  assign ent_nxt  = ent[IDX_W-1:0];
  assign is_match = (ent_bdf == key_q);
  assign is_empty = (ent == '0);
  assign is_tail  = (ent_nxt == '0);
  assign is_spent = (vis_q == CNT_W'(DEPTH - 1));

  always_comb begin
    st_n   = st_q;
    key_n  = key_q;
    idx_n  = idx_q;
    vis_n  = vis_q;
    done_n = 1'b0;
    hit_n  = hit_q;
    sid_n  = sid_q;
    unique case (st_q)
      WK_IDLE: begin
        if (start) begin
          st_n  = WK_RUN;
          key_n = start_bdf;
          idx_n = start_slot;
          vis_n = '0;
        end
      end
      WK_RUN: begin
        if (is_match) begin
          st_n   = WK_IDLE;
          done_n = 1'b1;
          hit_n  = 1'b1;
          sid_n  = base_sid + ent_rel;
        end else if (is_empty || is_tail || is_spent) begin
          st_n   = WK_IDLE;
          done_n = 1'b1;
          hit_n  = 1'b0;
          sid_n  = '0;
        end else begin
          idx_n = ent_nxt;
          vis_n = vis_q + 1'b1;
        end
      end
      default: st_n = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WK_IDLE;
      key_q  <= '0;
      idx_q  <= '0;
      vis_q  <= '0;
      done_q <= 1'b0;
      hit_q  <= 1'b0;
      sid_q  <= '0;
    end else begin
      st_q   <= st_n;
      key_q  <= key_n;
      idx_q  <= idx_n;
      vis_q  <= vis_n;
      done_q <= done_n;
      hit_q  <= hit_n;
      sid_q  <= sid_n;
    end
  end

  assign busy   = (st_q == WK_RUN);
  assign rd_idx = idx_q;
  assign done   = done_q;
  assign hit    = hit_q;
  assign sid    = sid_q;

endmodule

// File: rtl/sid_hash_lookup.sv
// Top: table, base register, hash and chain walker.
module sid_hash_lookup
  import sid_lut_pkg::*;
#(
  parameter int unsigned      BDF_W = DEF_BDF_W,
  parameter int unsigned      SID_W = DEF_SID_W,
  parameter int unsigned      IDX_W = DEF_IDX_W,
  parameter logic [IDX_W-1:0] POLY  = 8'h07,
  localparam int unsigned     ENTRY_W = BDF_W + SID_W + IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [IDX_W-1:0]   cfg_addr,
  input  logic [ENTRY_W-1:0] cfg_wdata,
  input  logic               cfg_base_wr,
  input  logic [SID_W-1:0]   cfg_base_wdata,
  output logic               cfg_ready,
  output logic [ENTRY_W-1:0] cfg_rdata,
  output logic [SID_W-1:0]   cfg_base_rdata,
  input  logic               req_valid,
  input  logic [BDF_W-1:0]   req_bdf,
  output logic               req_ready,
  output logic               rsp_done,
  output logic               rsp_hit,
  output logic [SID_W-1:0]   rsp_sid
);

  logic               walk_busy;
  logic               walk_start;
  logic               tbl_we;
  logic               base_we;
  logic [IDX_W-1:0]   head_slot;
  logic [IDX_W-1:0]   walk_idx;
  logic [ENTRY_W-1:0] walk_ent;
  logic [SID_W-1:0]   base_q;

  assign req_ready  = !walk_busy;
  assign cfg_ready  = !walk_busy;
  assign walk_start = req_valid && req_ready;
  assign tbl_we     = cfg_wr && cfg_ready;
  assign base_we    = cfg_base_wr && cfg_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_we) begin
      base_q <= cfg_base_wdata;
    end
  end

  assign cfg_base_rdata = base_q;

  sid_slot_hash #(
    .KEY_W (BDF_W),
    .IDX_W (IDX_W),
    .POLY  (POLY)
  ) u_hash (
    .key  (req_bdf),
    .slot (head_slot)
  );

  sid_table_store #(
    .ENTRY_W (ENTRY_W),
    .IDX_W   (IDX_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (tbl_we),
    .wr_idx    (cfg_addr),
    .wr_data   (cfg_wdata),
    .rd_a_idx  (cfg_addr),
    .rd_a_data (cfg_rdata),
    .rd_b_idx  (walk_idx),
    .rd_b_data (walk_ent)
  );

  sid_chain_walker #(
    .BDF_W (BDF_W),
    .SID_W (SID_W),
    .IDX_W (IDX_W)
  ) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (walk_start),
    .start_bdf  (req_bdf),
    .start_slot (head_slot),
    .ent        (walk_ent),
    .base_sid   (base_q),
    .busy       (walk_busy),
    .rd_idx     (walk_idx),
    .done       (rsp_done),
    .hit        (rsp_hit),
    .sid        (rsp_sid)
  );

endmodule

// File: rtl/sid_hash_lookup_chk.sv
module sid_hash_lookup_chk #(
  parameter int unsigned SID_W   = 8,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned ENTRY_W = 32,
  localparam int unsigned DEPTH  = 1 << IDX_W,
  localparam int unsigned CW     = IDX_W + 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wr,
  input logic [IDX_W-1:0]   cfg_addr,
  input logic               cfg_ready,
  input logic [ENTRY_W-1:0] cfg_rdata,
  input logic               cfg_base_wr,
  input logic [SID_W-1:0]   cfg_base_rdata,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_done,
  input logic               rsp_hit,
  input logic [SID_W-1:0]   rsp_sid
);

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (req_valid && req_ready) begin
      busy_cnt <= '0;
    end else if (!req_ready) begin
      busy_cnt <= busy_cnt + 1'b1;
    end
  end

  AST_WALK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CW'(DEPTH)); // R9

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !rsp_hit) |-> (rsp_sid == '0)); // R7

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R10

  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R10

  AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_base_wr && !cfg_ready) |=> $stable(cfg_base_rdata)); // R11

  AST_TABLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_ready) |=> ($stable(cfg_rdata) || !$stable(cfg_addr))); // R11

endmodule

bind sid_hash_lookup sid_hash_lookup_chk #(
  .SID_W   (SID_W),
  .IDX_W   (IDX_W),
  .ENTRY_W (ENTRY_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_wr         (cfg_wr),
  .cfg_addr       (cfg_addr),
  .cfg_ready      (cfg_ready),
  .cfg_rdata      (cfg_rdata),
  .cfg_base_wr    (cfg_base_wr),
  .cfg_base_rdata (cfg_base_rdata),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .rsp_done       (rsp_done),
  .rsp_hit        (rsp_hit),
  .rsp_sid        (rsp_sid)
);

// File: tb/sid_hash_lookup_test.sv
`timescale 1ns/1ps
module sid_hash_lookup_test;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        cfg_base_wr;
  logic [7:0]  cfg_base_wdata;
  logic        cfg_ready;
  logic [31:0] cfg_rdata;
  logic [7:0]  cfg_base_rdata;
  logic        req_valid;
  logic [15:0] req_bdf;
  logic        req_ready;
  logic        rsp_done;
  logic        rsp_hit;
  logic [7:0]  rsp_sid;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit finished = 0;

  sid_hash_lookup uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr         (cfg_wr),
    .cfg_addr       (cfg_addr),
    .cfg_wdata      (cfg_wdata),
    .cfg_base_wr    (cfg_base_wr),
    .cfg_base_wdata (cfg_base_wdata),
    .cfg_ready      (cfg_ready),
    .cfg_rdata      (cfg_rdata),
    .cfg_base_rdata (cfg_base_rdata),
    .req_valid      (req_valid),
    .req_bdf        (req_bdf),
    .req_ready      (req_ready),
    .rsp_done       (rsp_done),
    .rsp_hit        (rsp_hit),
    .rsp_sid        (rsp_sid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<=150000 cycles", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [7:0] ref_crc(input logic [15:0] k);
    logic [7:0] c = 8'h00;
    for (int b = 15; b >= 0; b--) begin
      if (c[7] ^ k[b]) c = {c[6:0], 1'b0} ^ 8'h07;
      else             c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tbl_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr  = a;
    cfg_wdata = d;
    cfg_wr    = 1'b1;
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  task automatic base_write(input logic [7:0] d);
    @(negedge clk);
    cfg_base_wdata = d;
    cfg_base_wr    = 1'b1;
    @(negedge clk);
    cfg_base_wr    = 1'b0;
  endtask

  // Present a request, return number of visited entries (cycles to done).
  task automatic lookup(input logic [15:0] bdf, output int n);
    @(negedge clk);
    req_bdf   = bdf;
    req_valid = 1'b1;
    @(posedge clk);
    n = 0;
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      if (rsp_done) break;
      n = n + 1;
      if (n > 400) break;
    end
  endtask

  function automatic logic [31:0] mk_ent(input logic [15:0] b, input logic [7:0] r, input logic [7:0] nx);
    return {b, r, nx};
  endfunction

  initial begin
    int n;
    logic [7:0]  base;
    logic [15:0] bdf;
    logic [7:0]  slot;
    logic [15:0] col_b;
    logic [15:0] col_d;
    logic [15:0] emp_k;
    logic [15:0] cyc_k;
    rst_n = 1'b0;
    cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    cfg_base_wr = 1'b0; cfg_base_wdata = '0;
    req_valid = 1'b0; req_bdf = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 req_ready", 32'(req_ready), 32'd1);
    chk("R1 cfg_ready", 32'(cfg_ready), 32'd1);
    chk("R1 rsp_done", 32'(rsp_done), 32'd0);
    chk("R1 base", 32'(cfg_base_rdata), 32'd0);
    for (int a = 0; a < 256; a++) begin
      cfg_addr = 8'(a);
      #0.1;
      chk("R1 table zero", cfg_rdata, 32'd0);
    end

    // R3 known vector
    chk("R3 crc 0x0100", 32'(ref_crc(16'h0100)), 32'd21);

    // R12 base load
    base = 8'h30;
    base_write(base);
    chk("R12 base readback", 32'(cfg_base_rdata), 32'(base));

    // R2 R3 R4 R5 sweep: each ID in its own hashed slot
    for (int i = 0; i < 256; i++) begin
      bdf  = {8'(i), ~8'(i)};
      slot = ref_crc(bdf);
      tbl_write(slot, mk_ent(bdf, 8'(i), 8'h00));
      chk("R2 readback", cfg_rdata, mk_ent(bdf, 8'(i), 8'h00));
      lookup(bdf, n);
      chk("R3 hit", 32'(rsp_hit), 32'd1);
      chk("R5 sid", 32'(rsp_sid), 32'(8'(base + 8'(i))));
      chk("R6 one visit", 32'(n), 32'd1);
      tbl_write(slot, 32'h0);
    end

    // R10 done is a single pulse
    @(negedge clk);
    chk("R10 done pulse", 32'(rsp_done), 32'd0);

    // Collision search for slot 21
    col_b = '0; col_d = '0;
    for (int k = 1; k < 65536; k++) begin
      if (ref_crc(16'(k)) == 8'd21 && 16'(k) != 16'h0100) begin
        if (col_b == 16'h0) col_b = 16'(k);
        else if (col_d == 16'h0) begin col_d = 16'(k); break; end
      end
    end

    // R6 chain: 21 -> 200 -> 201
    tbl_write(8'd21,  mk_ent(col_b,   8'h03, 8'd200));
    tbl_write(8'd200, mk_ent(16'h1234, 8'h04, 8'd201));
    tbl_write(8'd201, mk_ent(16'h0100, 8'h05, 8'h00));
    lookup(16'h0100, n);
    chk("R6 chain hit", 32'(rsp_hit), 32'd1);
    chk("R6 chain sid", 32'(rsp_sid), 32'(8'(base + 8'h05)));
    chk("R6 chain visits", 32'(n), 32'd3);
    chk("R10 ready at done", 32'(req_ready), 32'd1);
    lookup(col_b, n);
    chk("R4 head match", 32'(rsp_hit), 32'd1);
    chk("R4 head sid", 32'(rsp_sid), 32'(8'(base + 8'h03)));
    chk("R4 head visits", 32'(n), 32'd1);
    lookup(col_d, n);
    chk("R7 tail miss", 32'(rsp_hit), 32'd0);
    chk("R7 tail sid", 32'(rsp_sid), 32'd0);
    chk("R7 tail visits", 32'(n), 32'd3);

    // R7 empty slot miss
    emp_k = '0;
    for (int k = 1; k < 65536; k++) begin
      if (ref_crc(16'(k)) == 8'd100) begin emp_k = 16'(k); break; end
    end
    lookup(emp_k, n);
    chk("R7 empty miss", 32'(rsp_hit), 32'd0);
    chk("R7 empty visits", 32'(n), 32'd1);

    // R8 zero ID on empty slot 0
    lookup(16'h0000, n);
    chk("R8 zero hit", 32'(rsp_hit), 32'd1);
    chk("R8 zero sid", 32'(rsp_sid), 32'(base));

    // R9 self loop at slot 50, with R11 hold-off during the walk
    cyc_k = '0;
    for (int k = 1; k < 65536; k++) begin
      if (ref_crc(16'(k)) == 8'd50 && 16'(k) != 16'hABCD) begin cyc_k = 16'(k); break; end
    end
    tbl_write(8'd50, mk_ent(16'hABCD, 8'h01, 8'd50));
    @(negedge clk);
    req_bdf = cyc_k;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 busy after accept", 32'(req_ready), 32'd0);
    chk("R11 cfg_ready low", 32'(cfg_ready), 32'd0);
    cfg_addr = 8'd7; cfg_wdata = 32'hDEADBEEF; cfg_wr = 1'b1;
    cfg_base_wdata = 8'h77; cfg_base_wr = 1'b1;
    n = 1;
    forever begin
      @(negedge clk);
      if (rsp_done) break;
      n = n + 1;
      if (n > 400) break;
    end
    cfg_wr = 1'b0; cfg_base_wr = 1'b0;
    chk("R9 loop miss", 32'(rsp_hit), 32'd0);
    chk("R9 loop visits", 32'(n), 32'd256);
    cfg_addr = 8'd7;
    #0.1;
    chk("R11 table unchanged", cfg_rdata, 32'd0);
    chk("R11 base unchanged", 32'(cfg_base_rdata), 32'(base));

    // R12 R5 base wrap
    base = 8'hF0;
    base_write(base);
    tbl_write(8'd21, mk_ent(16'h0100, 8'h20, 8'h00));
    lookup(16'h0100, n);
    chk("R12 new base", 32'(rsp_sid), 32'h10);
    chk("R5 wrap hit", 32'(rsp_hit), 32'd1);

    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule